// File: doc/BRIEF.md
# Signed Integer Divider with Selectable Rounding

This block divides one two's-complement integer by another and returns both a quotient and a remainder. For each operation the caller picks one of two rounding conventions. Truncating mode rounds the quotient toward zero. Flooring mode rounds the quotient toward negative infinity, and the remainder then follows the sign of the divisor. The operand width is a parameter.

An operation starts with a one-cycle `start` pulse while the block is idle. The operands and the rounding mode are captured on that cycle. A radix-2 restoring loop works on the operand magnitudes and produces one quotient bit per clock. Two registered correction stages then apply the signs and, in flooring mode, the floor adjustment. The results appear together with a one-cycle `done` pulse and stay unchanged until the next operation completes.

A zero divisor raises `div_zero` and gives fixed output values. The one case that overflows, the most negative dividend divided by minus one, wraps and raises `ovf`. Neither case changes the latency.

Top module: `sdiv_rmode`

## Requirements
- R1: With `rmode`=0 (truncate) and a nonzero divisor, `quot` equals the true quotient rounded toward zero.
- R2: With `rmode`=0 and a nonzero divisor, `rem` is zero or carries the sign of the dividend, and |rem| < |divisor|.
- R3: With `rmode`=1 (floor) and a nonzero divisor, `quot` equals the true quotient rounded toward negative infinity.
- R4: With `rmode`=1 and a nonzero divisor, `rem` is zero or carries the sign of the divisor, and |rem| < |divisor|.
- R5: For every nonzero divisor in both modes, dividend = quot*divisor + rem, taken modulo 2^WIDTH.
- R6: A zero divisor gives `div_zero`=1, `quot` all ones, `rem` equal to the dividend and `ovf`=0.
- R7: The most negative dividend divided by -1 gives `quot` equal to the most negative value, `rem`=0 and `ovf`=1 in both modes. It takes the same latency as any other operation.
- R8: `done` is high for exactly one cycle, at the WIDTH+2-th rising edge after the edge that accepted `start`. `busy` is high from the accepting edge until that edge.
- R9: A `start` that arrives while `busy` is high is ignored. Operands and `rmode` are sampled only on the accepted `start`, so changing them during an operation has no effect on its result.
- R10: `quot`, `rem`, `div_zero` and `ovf` hold their values between `done` pulses.
- R11: After reset, `busy`, `done`, `quot`, `rem`, `div_zero` and `ovf` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start request, accepted only when idle |
| rmode | input | 1 | Rounding: 0 truncate, 1 floor |
| dividend | input | WIDTH | Signed dividend |
| divisor | input | WIDTH | Signed divisor |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| quot | output | WIDTH | Signed quotient |
| rem | output | WIDTH | Signed remainder |
| div_zero | output | 1 | Divisor was zero; results are fixed placeholders |
| ovf | output | 1 | Quotient overflowed (most negative / -1) |

## Verification
The bench tries all four sign combinations with an inexact result in both modes. A design that skips the floor fix would return the truncated pair, and one that applies the fix for every sign would get it wrong when the signs agree. Exact divisions with mixed signs check that the fix is skipped when the remainder is zero; a design that tested only the signs would step the quotient by one. A sweep over boundary operands checks the identity and the exact values, and it catches a magnitude path that mishandles the most negative operand. Directed cases cover a zero divisor, the overflow case, and a second `start` with new operands and a new mode sent mid-run. A design that restarted or resampled on that second `start` would return the wrong answer or change its `done` timing.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic {
    RND_TRUNC = 1'b0,
    RND_FLOOR = 1'b1
  } rnd_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_SIGN  = 2'd2,
    ST_FLOOR = 2'd3
  } div_state_e;
endpackage

// File: rtl/sdiv_seq.sv
module sdiv_seq
  import sdiv_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic step,
  output logic sign_en,
  output logic floor_en,
  output logic busy,
  output logic done
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  div_state_e state;
  logic [CW-1:0] cnt;
  logic last_step;

  assign accept    = (state == ST_IDLE) && start;
  assign step      = (state == ST_RUN);
  assign sign_en   = (state == ST_SIGN);
  assign floor_en  = (state == ST_FLOOR);
  assign busy      = (state != ST_IDLE);
  assign last_step = step && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= floor_en;
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_RUN;
          cnt   <= '0;
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (last_step) state <= ST_SIGN;
        end
        ST_SIGN:  state <= ST_FLOOR;
        ST_FLOOR: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R9: a start seen mid-run does not rewind the step counter
  p_count_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last_step) |=> (step && cnt == $past(cnt) + 1'b1));

  // R8: the loop always hands over to the sign stage after its last step
  p_run_to_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> sign_en);
endmodule

// File: rtl/sdiv_mag_core.sv
module sdiv_mag_core #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] qmag,
  output logic [WIDTH-1:0] rmag
);
  function automatic logic [WIDTH-1:0] magnitude(input logic [WIDTH-1:0] x);
    return x[WIDTH-1] ? (~x + 1'b1) : x;
  endfunction

  logic [WIDTH-1:0] divm;
  logic [WIDTH-1:0] part;
  logic [WIDTH-1:0] dq;
  logic [WIDTH:0]   trial;
  logic             fits;

  assign trial = {part, dq[WIDTH-1]};
  assign fits  = (trial >= {1'b0, divm});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divm <= '0;
      part <= '0;
      dq   <= '0;
    end else if (load) begin
      divm <= magnitude(b_i);
      part <= '0;
      dq   <= magnitude(a_i);
    end else if (step) begin
      part <= fits ? WIDTH'(trial - {1'b0, divm}) : trial[WIDTH-1:0];
      dq   <= {dq[WIDTH-2:0], fits};
    end
  end

  assign qmag = dq;
  assign rmag = part;

  // R2/R4: the partial remainder never reaches the divisor magnitude
  p_part_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && divm != '0) |=> (part < divm));
endmodule

// File: rtl/sdiv_fixup.sv
module sdiv_fixup
  import sdiv_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sign_en,
  input  logic             floor_en,
  input  logic [WIDTH-1:0] qmag,
  input  logic [WIDTH-1:0] rmag,
  input  logic [WIDTH-1:0] a_q,
  input  logic [WIDTH-1:0] b_q,
  input  rnd_mode_e        mode_q,
  input  logic             dz_q,
  input  logic             ovf_q,
  output logic [WIDTH-1:0] quot,
  output logic [WIDTH-1:0] rem,
  output logic             dz_o,
  output logic             ovf_o
);
  function automatic logic [WIDTH-1:0] with_sign(input logic [WIDTH-1:0] m, input logic neg);
    return neg ? (~m + 1'b1) : m;
  endfunction

  function automatic logic needs_floor(input rnd_mode_e m, input logic [WIDTH-1:0] r,
                                       input logic sa, input logic sb);
    return (m == RND_FLOOR) && (r != '0) && (sa != sb);
  endfunction

  logic [WIDTH-1:0] qs, rs;
  logic             adj;

  assign adj = needs_floor(mode_q, rs, a_q[WIDTH-1], b_q[WIDTH-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qs <= '0;
      rs <= '0;
    end else if (sign_en) begin
      qs <= with_sign(qmag, a_q[WIDTH-1] ^ b_q[WIDTH-1]);
      rs <= with_sign(rmag, a_q[WIDTH-1]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quot  <= '0;
      rem   <= '0;
      dz_o  <= 1'b0;
      ovf_o <= 1'b0;
    end else if (floor_en) begin
      dz_o  <= dz_q;
      ovf_o <= ovf_q;
      if (dz_q) begin
        quot <= '1;
        rem  <= a_q;
      end else if (adj) begin
        quot <= qs - 1'b1;
        rem  <= rs + b_q;
      end else begin
        quot <= qs;
        rem  <= rs;
      end
    end
  end

  // R4: floor mode leaves a remainder that follows the divisor's sign
  p_floor_rem_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (floor_en && mode_q == RND_FLOOR && !dz_q) |=> (rem == '0 || rem[WIDTH-1] == b_q[WIDTH-1]));

  // R2: truncate mode leaves a remainder that follows the dividend's sign
  p_trunc_rem_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (floor_en && mode_q == RND_TRUNC && !dz_q) |=> (rem == '0 || rem[WIDTH-1] == a_q[WIDTH-1]));
endmodule

// File: rtl/sdiv_rmode.sv
module sdiv_rmode
  import sdiv_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rmode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quot,
  output logic [WIDTH-1:0] rem,
  output logic             div_zero,
  output logic             ovf
);
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic             accept, step, sign_en, floor_en;
  logic [WIDTH-1:0] a_q, b_q, qmag, rmag;
  rnd_mode_e        mode_q;
  logic             dz_q, ovf_q;

  sdiv_seq #(.WIDTH(WIDTH)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept), .step(step),
    .sign_en(sign_en), .floor_en(floor_en), .busy(busy), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      mode_q <= RND_TRUNC;
      dz_q   <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (accept) begin
      a_q    <= dividend;
      b_q    <= divisor;
      mode_q <= rnd_mode_e'(rmode);
      dz_q   <= (divisor == '0);
      ovf_q  <= (dividend == MOST_NEG) && (divisor == '1);
    end
  end

  sdiv_mag_core #(.WIDTH(WIDTH)) core_i (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(step),
    .a_i(dividend), .b_i(divisor), .qmag(qmag), .rmag(rmag)
  );

  sdiv_fixup #(.WIDTH(WIDTH)) fix_i (
    .clk(clk), .rst_n(rst_n), .sign_en(sign_en), .floor_en(floor_en),
    .qmag(qmag), .rmag(rmag), .a_q(a_q), .b_q(b_q), .mode_q(mode_q),
    .dz_q(dz_q), .ovf_q(ovf_q), .quot(quot), .rem(rem), .dz_o(div_zero), .ovf_o(ovf)
  );

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R8: the block is idle whenever done is shown
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);

  // R10: results do not move between completions
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quot) && $stable(rem) && $stable(div_zero) && $stable(ovf)));

  // R7: overflow result wraps to the most negative value with zero remainder
  p_ovf_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovf) |-> (quot == MOST_NEG && rem == '0));

  // R6: divide-by-zero gives the fixed placeholder and no overflow
  p_dz_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_zero) |-> (quot == '1 && !ovf));
endmodule

// File: tb/sdiv_rmode_tb_top.sv
module sdiv_rmode_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rmode = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic busy, done, div_zero, ovf;
  logic [W-1:0] quot, rem;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sdiv_rmode #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rmode(rmode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quot(quot), .rem(rem), .div_zero(div_zero), .ovf(ovf)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  // expected values from real arithmetic, wrapped to W bits
  task automatic expect_div(input int a, input int b, input bit fl,
                            output logic [W-1:0] eq, output logic [W-1:0] er);
    int q;
    if (b == 0) begin
      eq = '1;
      er = W'(a);
    end else begin
      if (fl) q = int'($floor(real'(a) / real'(b)));
      else    q = a / b;
      eq = W'(q);
      er = W'(a - q * b);
    end
  endtask

  // drive one start pulse; returns the edge count until done
  task automatic launch(input int a, input int b, input bit fl, output int lat);
    @(negedge clk);
    dividend = W'(a);
    divisor  = W'(b);
    rmode    = fl;
    start    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int i = 1; i <= 40; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (done) begin
        lat = i;
        break;
      end
    end
  endtask

  task automatic t_one(input int a, input int b, input bit fl, input string req);
    int lat;
    logic [W-1:0] eq, er;
    expect_div(a, b, fl, eq, er);
    launch(a, b, fl, lat);
    chk(lat == W + 2, "R8", "latency", lat, W + 2);
    chk(quot == eq, req, $sformatf("quot %0d/%0d m%0d", a, b, fl), $signed(quot), $signed(eq));
    chk(rem == er, req, $sformatf("rem %0d/%0d m%0d", a, b, fl), $signed(rem), $signed(er));
    chk(div_zero == (b == 0), "R6", "div_zero", div_zero, b == 0);
    chk(ovf == (a == -(2**(W-1)) && b == -1), "R7", "ovf", ovf, a == -(2**(W-1)) && b == -1);
    if (b != 0)
      chk(W'(a) == W'($signed(quot) * b + $signed(rem)), "R5", "identity",
          $signed(quot) * b + $signed(rem), a);
  endtask

  task automatic t_reset();
    chk(busy == 0 && done == 0, "R11", "busy/done after reset", {busy, done}, 0);
    chk(quot == 0 && rem == 0, "R11", "quot/rem after reset", {quot, rem}, 0);
    chk(div_zero == 0 && ovf == 0, "R11", "flags after reset", {div_zero, ovf}, 0);
  endtask

  task automatic t_signs();
    t_one( 7,  2, 0, "R1"); t_one(-7,  2, 0, "R2");
    t_one( 7, -2, 0, "R1"); t_one(-7, -2, 0, "R2");
    t_one( 7,  2, 1, "R3"); t_one(-7,  2, 1, "R4");
    t_one( 7, -2, 1, "R3"); t_one(-7, -2, 1, "R4");
    t_one(-6,  3, 1, "R3"); t_one( 6, -3, 1, "R4");
  endtask

  task automatic t_corners();
    t_one(-128, -1, 0, "R7");
    t_one(-128, -1, 1, "R7");
    t_one(  45,  0, 0, "R6");
    t_one( -90,  0, 1, "R6");
  endtask

  task automatic t_sweep();
    int av[9] = '{-128, -77, -9, -1, 0, 1, 5, 63, 127};
    int bv[8] = '{-128, -5, -3, -1, 1, 2, 7, 127};
    foreach (av[i])
      foreach (bv[j]) begin
        t_one(av[i], bv[j], 0, "R5");
        t_one(av[i], bv[j], 1, "R5");
      end
  endtask

  task automatic t_busy_ignore();
    int lat;
    @(negedge clk);
    dividend = W'(100); divisor = W'(7); rmode = 1'b0; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int i = 1; i <= 40; i++) begin
      if (i == 3) begin
        dividend = W'(-50); divisor = W'(3); rmode = 1'b1; start = 1'b1;
      end else if (i == 4) begin
        start = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      if (done) begin
        lat = i;
        break;
      end
    end
    chk(lat == W + 2, "R9", "latency with mid-run start", lat, W + 2);
    chk($signed(quot) == 14, "R9", "quot keeps first operands", $signed(quot), 14);
    chk($signed(rem) == 2, "R9", "rem keeps first operands", $signed(rem), 2);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!done && !busy, "R9", "no second run", {done, busy}, 0);
      chk($signed(quot) == 14 && $signed(rem) == 2, "R10", "results held",
          $signed(quot), 14);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_signs();
    t_corners();
    t_busy_ignore();
    t_sweep();
    repeat (3) @(negedge clk);
    report();
  end
endmodule